// File: doc/BRIEF.md
# Serial-Loaded Control Register Bank with Bias-State Decode

This block is a write-only, three-wire serial slave. It takes an active-low chip select, a serial clock and a serial data line, assembles 20-bit frames and writes them into a bank of four 16-bit control registers. The last four bits shifted in select the target register and the first sixteen carry its contents. A frame takes effect only when chip select returns high, and only if exactly twenty bits arrived in between.

The serial pins are oversampled on the system clock. Each pin passes through a two-stage synchronizer and the serial clock edges are detected in the system domain, so all state lives in one clock domain. The serial clock must therefore run well below the system clock, with each serial level held for at least three system cycles.

From the operation-control register and an active-low hardware power-off pin, the block decodes a three-level bias state (shutdown, idle, on). It registers that state and drives enable lines for the receive path, the synthesizer and the serial interface. A hardware power-off freezes the serial port but keeps every register value. Only the power-on reset restores the defaults.

Top module: `sctl_bank`

## Requirements
- R1: A frame is shifted in most significant bit first, one bit on each rising edge of `spi_sclk_i` while `spi_csn_i` is low. Edges while `spi_csn_i` is high are not counted. Frame bits 3:0 are the address and bits 19:4 are the register data.
- R2: When `spi_csn_i` rises after a valid frame, the data is written to the register the address selects: 4'b0011 configuration (`cfg_o`), 4'b0111 operation control (`opctl_o`), 4'b1011 main divider (`mdiv_o`), 4'b1111 reference divider (`rdiv_o`).
- R3: A frame of any length other than 20 bits, whether shorter or longer, changes no register.
- R4: A 20-bit frame whose address is none of the four above changes no register.
- R5: While `rst_ni` is low, and after it is released, each register holds its parameter default. The defaults are 16'hA5C3, 16'h0000, 16'h0100 and 16'h0010.
- R6: The bias state on `bias_o` is 2'b00 (shutdown) when `hard_off_ni` is low or `opctl_o[5]` is 0. In shutdown, `rx_en_o` and `synth_en_o` are 0. The value 2'b11 never appears.
- R7: `ser_en_o` follows `hard_off_ni`. It stays 1 during a shutdown commanded by register bit 5 and is 0 during a pin shutdown.
- R8: The state is idle, 2'b01, when `hard_off_ni` is high, `opctl_o[5]` is 1 and `opctl_o[4]` is 0. In idle, `rx_en_o` is 0 and `synth_en_o` and `ser_en_o` are 1.
- R9: The state is on, 2'b10, when `hard_off_ni` is high and `opctl_o[5]` and `opctl_o[4]` are both 1. In this state all three enables are 1.
- R10: While `hard_off_ni` is low, serial frames are ignored and every register keeps its value. The values are still present after the pin returns high.
- R11: Bits of the operation-control register other than 5 and 4 have no effect on the bias state or the enables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low power-on reset |
| spi_csn_i | input | 1 | Serial chip select, active low |
| spi_sclk_i | input | 1 | Serial clock |
| spi_sdi_i | input | 1 | Serial data in |
| hard_off_ni | input | 1 | Hardware power-off pin, active low |
| cfg_o | output | 16 | Configuration register |
| opctl_o | output | 16 | Operation-control register |
| mdiv_o | output | 16 | Main divider register |
| rdiv_o | output | 16 | Reference divider register |
| bias_o | output | 2 | Bias state: 00 shutdown, 01 idle, 10 on |
| rx_en_o | output | 1 | Receive-path enable |
| synth_en_o | output | 1 | Synthesizer enable |
| ser_en_o | output | 1 | Serial-interface enable |

## Verification
The main write path is driven with random frames. Most use one of the four valid addresses with random data. Some carry a stray address, which separates correct decoding from loose matching on the high address bits. Some are one bit short or one bit long, which tells an exact length check apart from a check that the count merely reached 20. Directed frames then cover the decode cases. They walk the operation-control bits through all combinations of bits 5 and 4, with the don't-care bits at all-zero and at all-one. They also drop the power-off pin in the middle of a write, which shows whether pin shutdown both blocks the port and keeps the stored words.

// File: rtl/sctl_pkg.sv
package sctl_pkg;

  typedef enum logic [1:0] {
    BIAS_OFF  = 2'b00,
    BIAS_IDLE = 2'b01,
    BIAS_ON   = 2'b10
  } bias_e;

  localparam int NUM_REGS = 4;

  // Register index i answers at address {i, 2'b11}
  function automatic logic [3:0] reg_addr(input logic [1:0] idx);
    return {idx, 2'b11};
  endfunction

endpackage

// File: rtl/sctl_sync.sv
module sctl_sync #(
  parameter int               STAGES  = 2,
  parameter int               WIDTH   = 1,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  logic [STAGES-1:0][WIDTH-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chain_q <= {STAGES{RST_VAL}};
    end else begin
      chain_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) begin
        chain_q[s] <= chain_q[s-1];
      end
    end
  end

  assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/sctl_shifter.sv
module sctl_shifter #(
  parameter int FRAME_LEN = 20,
  parameter int ADDR_W    = 4,
  localparam int DATA_W   = FRAME_LEN - ADDR_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hw_on_i,
  input  logic              csn_i,
  input  logic              sclk_i,
  input  logic              sdi_i,
  output logic              wr_vld_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [DATA_W-1:0] wr_data_o
);

  localparam int               CNT_W    = $clog2(FRAME_LEN + 2);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_LEN);
  localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(FRAME_LEN + 1);

  logic [FRAME_LEN-1:0] sr_q, sr_d;
  logic [CNT_W-1:0]     cnt_q, cnt_d;
  logic                 sclk_q, csn_q;
  logic                 vld_q, vld_d;
  logic                 sclk_rise, cs_rise, shift_en;

  assign sclk_rise = sclk_i & ~sclk_q;
  assign cs_rise   = csn_i & ~csn_q;
  assign shift_en  = hw_on_i & ~csn_i & sclk_rise;

  always_comb begin
    sr_d  = sr_q;
    cnt_d = cnt_q;
    vld_d = 1'b0;
    if (!hw_on_i || csn_i) begin
      cnt_d = '0;
    end else if (shift_en) begin
      sr_d = {sr_q[FRAME_LEN-2:0], sdi_i};
      if (cnt_q != CNT_SAT) begin
        cnt_d = cnt_q + 1'b1;
      end
    end
    if (hw_on_i && cs_rise && (cnt_q == CNT_FULL)) begin
      vld_d = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q   <= '0;
      cnt_q  <= '0;
      sclk_q <= 1'b0;
      csn_q  <= 1'b1;
      vld_q  <= 1'b0;
    end else begin
      sr_q   <= sr_d;
      cnt_q  <= cnt_d;
      sclk_q <= sclk_i;
      csn_q  <= csn_i;
      vld_q  <= vld_d;
    end
  end

  assign wr_vld_o  = vld_q;
  assign wr_addr_o = sr_q[ADDR_W-1:0];
  assign wr_data_o = sr_q[FRAME_LEN-1:ADDR_W];

  // R3
  frame_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_vld_o |-> ($past(cnt_q) == CNT_FULL));

  // R10
  pin_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hw_on_i |=> !wr_vld_o);

  // R1
  cs_high_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (csn_i && $past(csn_i)) |=> $stable(sr_q));

endmodule

// File: rtl/sctl_regbank.sv
module sctl_regbank
  import sctl_pkg::*;
#(
  parameter int                         DATA_W  = 16,
  parameter int                         ADDR_W  = 4,
  parameter logic [NUM_REGS*DATA_W-1:0] RST_VAL = '0
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       wr_vld_i,
  input  logic [ADDR_W-1:0]          wr_addr_i,
  input  logic [DATA_W-1:0]          wr_data_i,
  output logic [NUM_REGS*DATA_W-1:0] regs_o
);

  logic [NUM_REGS-1:0] sel;
  logic                hit;

  assign hit = |sel;

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    logic [DATA_W-1:0] val_q, val_d;
    logic              we;

    assign sel[i] = (wr_addr_i == ADDR_W'(reg_addr(2'(i))));
    assign we     = wr_vld_i & sel[i];

    always_comb begin
      val_d = val_q;
      if (we) begin
        val_d = wr_data_i;
      end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        val_q <= RST_VAL[i*DATA_W +: DATA_W];
      end else begin
        val_q <= val_d;
      end
    end

    assign regs_o[i*DATA_W +: DATA_W] = val_q;

    // R2
    reg_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_vld_i && wr_addr_i == ADDR_W'(reg_addr(2'(i)))) |=> (val_q == $past(wr_data_i)));
  end

  // R4
  stray_addr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_vld_i && !hit) |=> $stable(regs_o));

  // R2
  one_hot_sel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(sel));

endmodule

// File: rtl/sctl_bias.sv
module sctl_bias
  import sctl_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int SHDN_BIT = 5,
  parameter int IDLE_BIT = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hw_on_i,
  input  logic [DATA_W-1:0] opctl_i,
  output logic [1:0]        bias_o,
  output logic              rx_en_o,
  output logic              synth_en_o,
  output logic              ser_en_o
);

  bias_e state_q, state_d;
  logic  rx_q, rx_d, syn_q, syn_d, ser_q, ser_d;

  always_comb begin
    if (!hw_on_i || !opctl_i[SHDN_BIT]) begin
      state_d = BIAS_OFF;
    end else if (!opctl_i[IDLE_BIT]) begin
      state_d = BIAS_IDLE;
    end else begin
      state_d = BIAS_ON;
    end
    rx_d  = (state_d == BIAS_ON);
    syn_d = (state_d == BIAS_ON) || (state_d == BIAS_IDLE);
    ser_d = hw_on_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= BIAS_OFF;
      rx_q    <= 1'b0;
      syn_q   <= 1'b0;
      ser_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      rx_q    <= rx_d;
      syn_q   <= syn_d;
      ser_q   <= ser_d;
    end
  end

  assign bias_o     = state_q;
  assign rx_en_o    = rx_q;
  assign synth_en_o = syn_q;
  assign ser_en_o   = ser_q;

  // R6
  no_bad_state_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bias_o != 2'b11);

  // R7
  pin_off_ser_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hw_on_i |=> !ser_en_o);

  // R6
  reg_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !opctl_i[SHDN_BIT] |=> (!rx_en_o && !synth_en_o));

  // R8
  idle_en_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hw_on_i && opctl_i[SHDN_BIT] && !opctl_i[IDLE_BIT]) |=> (!rx_en_o && synth_en_o && ser_en_o));

endmodule

// File: rtl/sctl_bank.sv
module sctl_bank
  import sctl_pkg::*;
#(
  parameter int          FRAME_LEN = 20,
  parameter int          ADDR_W    = 4,
  parameter int          SYNC_LEN  = 2,
  parameter logic [15:0] CFG_RST   = 16'hA5C3,
  parameter logic [15:0] OPCTL_RST = 16'h0000,
  parameter logic [15:0] MDIV_RST  = 16'h0100,
  parameter logic [15:0] RDIV_RST  = 16'h0010
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        spi_csn_i,
  input  logic        spi_sclk_i,
  input  logic        spi_sdi_i,
  input  logic        hard_off_ni,
  output logic [15:0] cfg_o,
  output logic [15:0] opctl_o,
  output logic [15:0] mdiv_o,
  output logic [15:0] rdiv_o,
  output logic [1:0]  bias_o,
  output logic        rx_en_o,
  output logic        synth_en_o,
  output logic        ser_en_o
);

  localparam int DATA_W = FRAME_LEN - ADDR_W;
  localparam logic [NUM_REGS*DATA_W-1:0] BANK_RST =
    {RDIV_RST, MDIV_RST, OPCTL_RST, CFG_RST};

  logic [1:0]                 rst_sync_q;
  logic                       rst_n;
  logic [3:0]                 pins_s;
  logic                       csn_s, sclk_s, sdi_s, hw_on_s;
  logic                       wr_vld;
  logic [ADDR_W-1:0]          wr_addr;
  logic [DATA_W-1:0]          wr_data;
  logic [NUM_REGS*DATA_W-1:0] regs;

  // Reset asserts at once and releases on the clock
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_n = rst_sync_q[1];

  sctl_sync #(
    .STAGES (SYNC_LEN),
    .WIDTH  (4),
    .RST_VAL(4'b1000)
  ) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_n),
    .d_i   ({spi_csn_i, spi_sclk_i, spi_sdi_i, hard_off_ni}),
    .q_o   (pins_s)
  );
  assign {csn_s, sclk_s, sdi_s, hw_on_s} = pins_s;

  sctl_shifter #(
    .FRAME_LEN(FRAME_LEN),
    .ADDR_W   (ADDR_W)
  ) i_shifter (
    .clk_i    (clk_i),
    .rst_ni   (rst_n),
    .hw_on_i  (hw_on_s),
    .csn_i    (csn_s),
    .sclk_i   (sclk_s),
    .sdi_i    (sdi_s),
    .wr_vld_o (wr_vld),
    .wr_addr_o(wr_addr),
    .wr_data_o(wr_data)
  );

  sctl_regbank #(
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W),
    .RST_VAL(BANK_RST)
  ) i_regbank (
    .clk_i    (clk_i),
    .rst_ni   (rst_n),
    .wr_vld_i (wr_vld),
    .wr_addr_i(wr_addr),
    .wr_data_i(wr_data),
    .regs_o   (regs)
  );

  assign cfg_o   = regs[0*DATA_W +: 16];
  assign opctl_o = regs[1*DATA_W +: 16];
  assign mdiv_o  = regs[2*DATA_W +: 16];
  assign rdiv_o  = regs[3*DATA_W +: 16];

  sctl_bias #(
    .DATA_W  (DATA_W),
    .SHDN_BIT(5),
    .IDLE_BIT(4)
  ) i_bias (
    .clk_i     (clk_i),
    .rst_ni    (rst_n),
    .hw_on_i   (hw_on_s),
    .opctl_i   (regs[1*DATA_W +: DATA_W]),
    .bias_o    (bias_o),
    .rx_en_o   (rx_en_o),
    .synth_en_o(synth_en_o),
    .ser_en_o  (ser_en_o)
  );

  // R10
  pin_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    (!hw_on_s && $past(!hw_on_s)) |=> $stable(regs));

  // R9
  on_state_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    (bias_o == BIAS_ON) |-> (rx_en_o && synth_en_o && ser_en_o));

endmodule

// File: tb/test_sctl_bank.sv
module test_sctl_bank;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        csn = 1'b1, sclk = 1'b0, sdi = 1'b0, pin_n = 1'b1;
  logic [15:0] cfg, opctl, mdiv, rdiv;
  logic [1:0]  bias;
  logic        rx_en, syn_en, ser_en;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [15:0] exp_r [4];
  logic        pin_on;

  always #5 clk = ~clk;

  sctl_bank i_sctl_bank (
    .clk_i(clk), .rst_ni(rst_n), .spi_csn_i(csn), .spi_sclk_i(sclk),
    .spi_sdi_i(sdi), .hard_off_ni(pin_n), .cfg_o(cfg), .opctl_o(opctl),
    .mdiv_o(mdiv), .rdiv_o(rdiv), .bias_o(bias), .rx_en_o(rx_en),
    .synth_en_o(syn_en), .ser_en_o(ser_en)
  );

  function automatic logic [1:0] exp_bias(input logic on, input logic [15:0] op);
    if (!on || !op[5]) return 2'b00;
    if (!op[4])        return 2'b01;
    return 2'b10;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, expv);
    end
  endtask

  task automatic check_regs(input string req);
    chk(req, {16'h0, cfg},   {16'h0, exp_r[0]});
    chk(req, {16'h0, opctl}, {16'h0, exp_r[1]});
    chk(req, {16'h0, mdiv},  {16'h0, exp_r[2]});
    chk(req, {16'h0, rdiv},  {16'h0, exp_r[3]});
  endtask

  task automatic check_bias(input string req);
    logic [1:0] eb;
    eb = exp_bias(pin_on, exp_r[1]);
    chk(req, {30'h0, bias}, {30'h0, eb});
    chk(req, {31'h0, rx_en},  {31'h0, eb == 2'b10});
    chk(req, {31'h0, syn_en}, {31'h0, eb != 2'b00});
    chk(req, {31'h0, ser_en}, {31'h0, pin_on});
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Sends the low nbits of f, MSB first, and updates the model
  task automatic send(input logic [23:0] f, input int nbits);
    logic [3:0] a;
    @(negedge clk);
    csn = 1'b0;
    wait_clk(4);
    for (int b = nbits - 1; b >= 0; b--) begin
      sdi = f[b];
      wait_clk(4);
      sclk = 1'b1;
      wait_clk(4);
      sclk = 1'b0;
    end
    wait_clk(4);
    csn = 1'b1;
    wait_clk(12);
    a = f[3:0];
    if (nbits == 20 && pin_on && a[1:0] == 2'b11) exp_r[a[3:2]] = f[19:4];
  endtask

  task automatic set_pin(input logic on);
    @(negedge clk);
    pin_n = on;
    pin_on = on;
    wait_clk(8);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [3:0]  ra;
    logic [15:0] rd;
    int          len, rv;
    void'($urandom(32'h5C7B));
    exp_r[0] = 16'hA5C3; exp_r[1] = 16'h0000; exp_r[2] = 16'h0100; exp_r[3] = 16'h0010;
    pin_on = 1'b1;
    wait_clk(5);
    check_regs("R5 during reset");
    rst_n = 1'b1;
    wait_clk(10);
    check_regs("R5 after reset");
    check_bias("R6 R7 reset bias");

    // R1 R2: a distinct pattern to each register
    send({16'hC3A5, 4'b0011}, 20); check_regs("R1 R2 cfg");
    send({16'h8001, 4'b1011}, 20); check_regs("R2 mdiv");
    send({16'h7FFE, 4'b1111}, 20); check_regs("R2 rdiv");

    // R8 R9 R11: walk bits 5 and 4, with the don't-care bits at 0 and at 1
    send({16'h0020, 4'b0111}, 20); check_bias("R8 idle");
    send({16'h0030, 4'b0111}, 20); check_bias("R9 on");
    send({16'hFFCF, 4'b0111}, 20); check_bias("R11 off others set");
    send({16'hFFEF, 4'b0111}, 20); check_bias("R11 idle others set");
    send({16'hFFFF, 4'b0111}, 20); check_bias("R11 R9 on others set");
    send({16'h0010, 4'b0111}, 20); check_bias("R6 R7 reg shutdown");

    // R3: one bit short, one bit long
    send({4'h0, 16'h1111, 4'b0011}, 19); check_regs("R3 short");
    send({4'h0, 16'h2222, 4'b0011}, 21); check_regs("R3 long");
    // R4: stray addresses
    send({16'h3333, 4'b0001}, 20); check_regs("R4 stray 0001");
    send({16'h4444, 4'b1110}, 20); check_regs("R4 stray 1110");

    // R10 R7: pin shutdown blocks writes and keeps the values
    send({16'h0030, 4'b0111}, 20);
    set_pin(1'b0);
    check_bias("R7 pin shutdown");
    send({16'h5555, 4'b0011}, 20);
    send({16'h0000, 4'b0111}, 20);
    check_regs("R10 frozen");
    set_pin(1'b1);
    check_regs("R10 kept");
    check_bias("R9 on after pin");

    // Random frames, mostly valid, some stray or off-length
    for (int n = 0; n < 60; n++) begin
      rv = int'($urandom_range(0, 9));
      ra = (rv < 7) ? {2'($urandom_range(0, 3)), 2'b11} : 4'($urandom_range(0, 15));
      rd = 16'($urandom());
      len = 20;
      if (rv == 8) len = 19;
      if (rv == 9) len = 21;
      if ($urandom_range(0, 11) == 0) set_pin(~pin_on);
      send({4'h0, rd, ra}, len);
      check_regs("R1 R2 R3 R4 random");
      check_bias("R6 R8 R9 random");
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule